// File: doc/BRIEF.md
# In-System Programming Stage Sequencer

This block runs on the host side of an in-system programming link. It drives a nonvolatile programmable logic device through the whole programming flow. The block does not walk the four-wire test port itself. It asks a separate shift engine to move one instruction word or one data word at a time, using a request/done handshake, and it reads back the word that was captured from the target's serial output. The word that is expected at each address comes from a request/valid port. A memory or a host buffer supplies it.

A start pulse begins a run, and a mode bit sampled at that moment picks the run type. A full run enters programming mode, checks the silicon identifier, bulk-erases the device, programs every address and verifies every address, then leaves programming mode. A verify-only run skips the erase and program stages. Every settling wait and every pulse is timed by one shared down-counter. The settling and erase times are derived from the clock frequency parameter, and the program and read pulse widths are separate parameters. At the end the block raises a one-cycle completion strobe. A fail flag and a failing-stage code are held at that point, together with the first failing address when the failure happened in verify.

Top module: `isp_seq`

## Requirements
- R1: A full run issues these instruction codes in this order: OP_ENTER, OP_IDCODE, OP_ERASE, then OP_PROG once for each address, then OP_READ once for each address, then OP_EXIT. The `stage` output reads 1 (enter), 2 (identifier), 3 (erase), 4 (program), 5 (verify) and 6 (exit), and reads 0 when idle.
- R2: A run started with `verify_only`=1 issues OP_ENTER, OP_IDCODE, OP_READ for each address, then OP_EXIT. It never raises `pulse_on` in stage 3 or stage 4.
- R3: The enter stage holds a settling wait of CLK_HZ/1000 cycles after its instruction shift. The exit stage does the same. No shift is requested during either wait.
- R4: The erase stage shifts OP_ERASE and then holds `pulse_on` for exactly CLK_HZ/10 consecutive cycles.
- R5: The program stage visits addresses 0 to NADDR-1 in ascending order. For each address it first fetches the expected word. It then shifts OP_PROG and then a data word {address, data}, with the address in the upper AW bits and the data in the lower DW bits. Last, it holds `pulse_on` for PROG_CYC cycles.
- R6: The verify stage visits addresses 0 to NADDR-1 in ascending order. For each address it fetches the expected word, shifts OP_READ, shifts {address, zeros}, and holds `pulse_on` for READ_CYC cycles. It then shifts one more data word and compares the returned `sh_rdata` with the expected data, zero-extended.
- R7: The identifier is read with OP_IDCODE followed by one data shift, before any erase, program or verify activity. If the returned word differs from EXP_ID zero-extended, the run goes straight to the exit stage and ends with `fail`=1 and `fail_stage`=2.
- R8: A verify miscompare sets `fail` and keeps it set. It sets `fail_stage`=5 and records the first failing address in `fail_addr`. The verify pass still runs through the last address, and the exit stage still follows.
- R9: `done` is high for exactly one cycle, straight after the exit wait ends. `busy` is low in the next cycle.
- R10: A `start` while `busy` is high has no effect. A `start` accepted while idle clears `fail`, `fail_stage` and `fail_addr`.
- R11: `sh_req` stays high, with `sh_ir` and `sh_wdata` unchanged, until the cycle in which `sh_done` is seen. `exp_req` stays high, with `exp_addr` unchanged, until the cycle in which `exp_valid` is seen.
- R12: While reset is asserted, and whenever the block is idle, `busy`, `done`, `sh_req`, `exp_req` and `pulse_on` are low and `stage` is 0. Reset also clears `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (used only when idle) |
| verify_only | input | 1 | Sampled at start: 1 selects the verify-only run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| fail | output | 1 | Sticky failure flag of the last run |
| fail_stage | output | 3 | Stage code of the first failure (2 or 5) |
| fail_addr | output | AW | First address that miscompared in verify |
| stage | output | 3 | Current stage code, 0 when idle |
| sh_req | output | 1 | Shift request to the test-port engine |
| sh_ir | output | 1 | 1: instruction shift, 0: data shift |
| sh_wdata | output | AW+DW | Word to shift in |
| sh_done | input | 1 | Shift engine finished the requested shift |
| sh_rdata | input | AW+DW | Word captured from the target's serial output |
| pulse_on | output | 1 | Erase, program or read pulse in progress |
| exp_req | output | 1 | Request for the expected word |
| exp_addr | output | AW | Address of the requested word |
| exp_valid | input | 1 | Expected word is present |
| exp_data | input | DW | Expected word |

## Verification
Because the stage order is held in one state register, a wrong next state shows at the shift port as a wrong instruction code. This shows up at the very next instruction shift, which is at most a few handshakes later. A miscounted wait or pulse shows as a change in the number of cycles during which `pulse_on` is high, or during which `stage` is 1 or 6 with no shift requested. These counts are final when `done` rises. A corrupted address counter or expected-data register shows in the target model's memory after a full run, or as a wrong `fail_addr` when the verify pass finishes.

// File: rtl/isp_seq.sv
module isp_seq #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int NADDR    = 256,
  parameter int DW       = 16,
  parameter int IDW      = 16,
  parameter int IRW      = 10,
  parameter int PROG_CYC = 5000,
  parameter int READ_CYC = 50,
  parameter logic [IDW-1:0] EXP_ID = IDW'('h5A3C),
  parameter logic [IRW-1:0] OP_ENTER  = IRW'('h202),
  parameter logic [IRW-1:0] OP_IDCODE = IRW'('h059),
  parameter logic [IRW-1:0] OP_ERASE  = IRW'('h2F2),
  parameter logic [IRW-1:0] OP_PROG   = IRW'('h1F4),
  parameter logic [IRW-1:0] OP_READ   = IRW'('h205),
  parameter logic [IRW-1:0] OP_EXIT   = IRW'('h201),
  localparam int AW = (NADDR > 1) ? $clog2(NADDR) : 1,
  localparam int SW = AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          verify_only,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [2:0]    fail_stage,
  output logic [AW-1:0] fail_addr,
  output logic [2:0]    stage,
  output logic          sh_req,
  output logic          sh_ir,
  output logic [SW-1:0] sh_wdata,
  input  logic          sh_done,
  input  logic [SW-1:0] sh_rdata,
  output logic          pulse_on,
  output logic          exp_req,
  output logic [AW-1:0] exp_addr,
  input  logic          exp_valid,
  input  logic [DW-1:0] exp_data
);
  localparam int SETTLE = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int ERASE  = (CLK_HZ / 10 > 0) ? CLK_HZ / 10 : 1;
  localparam int M1     = (SETTLE > ERASE) ? SETTLE : ERASE;
  localparam int M2     = (PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC;
  localparam int MAXC   = (M1 > M2) ? M1 : M2;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [AW-1:0] LAST = AW'(NADDR - 1);

  typedef enum logic [4:0] {
    IDLE, EN_IR, EN_WAIT, ID_IR, ID_DR, ER_IR, ER_WAIT,
    PG_FETCH, PG_IR, PG_DR, PG_WAIT,
    VF_FETCH, VF_IR, VF_ADR, VF_WAIT, VF_DR,
    EX_IR, EX_WAIT, FIN
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [DW-1:0] dat;
  logic          vmode;
  wire           cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      addr       <= '0;
      dat        <= '0;
      vmode      <= 1'b0;
      fail       <= 1'b0;
      fail_stage <= 3'd0;
      fail_addr  <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          vmode      <= verify_only;
          fail       <= 1'b0;
          fail_stage <= 3'd0;
          fail_addr  <= '0;
          addr       <= '0;
          st         <= EN_IR;
        end
        EN_IR: if (sh_done) begin
          cnt <= CW'(SETTLE - 1);
          st  <= EN_WAIT;
        end
        EN_WAIT: if (cnt_zero) st <= ID_IR; else cnt <= cnt - 1'b1;
        ID_IR: if (sh_done) st <= ID_DR;
        ID_DR: if (sh_done) begin
          if (sh_rdata != SW'(EXP_ID)) begin
            fail       <= 1'b1;
            fail_stage <= 3'd2;
            st         <= EX_IR;
          end else begin
            st <= vmode ? VF_FETCH : ER_IR;
          end
        end
        ER_IR: if (sh_done) begin
          cnt <= CW'(ERASE - 1);
          st  <= ER_WAIT;
        end
        ER_WAIT: if (cnt_zero) st <= PG_FETCH; else cnt <= cnt - 1'b1;
        PG_FETCH: if (exp_valid) begin
          dat <= exp_data;
          st  <= PG_IR;
        end
        PG_IR: if (sh_done) st <= PG_DR;
        PG_DR: if (sh_done) begin
          cnt <= CW'(PROG_CYC - 1);
          st  <= PG_WAIT;
        end
        PG_WAIT: if (cnt_zero) begin
          if (addr == LAST) begin
            addr <= '0;
            st   <= VF_FETCH;
          end else begin
            addr <= addr + 1'b1;
            st   <= PG_FETCH;
          end
        end else cnt <= cnt - 1'b1;
        VF_FETCH: if (exp_valid) begin
          dat <= exp_data;
          st  <= VF_IR;
        end
        VF_IR: if (sh_done) st <= VF_ADR;
        VF_ADR: if (sh_done) begin
          cnt <= CW'(READ_CYC - 1);
          st  <= VF_WAIT;
        end
        VF_WAIT: if (cnt_zero) st <= VF_DR; else cnt <= cnt - 1'b1;
        VF_DR: if (sh_done) begin
          if (sh_rdata != SW'(dat) && !fail) begin
            fail       <= 1'b1;
            fail_stage <= 3'd5;
            fail_addr  <= addr;
          end
          if (addr == LAST) st <= EX_IR;
          else begin
            addr <= addr + 1'b1;
            st   <= VF_FETCH;
          end
        end
        EX_IR: if (sh_done) begin
          cnt <= CW'(SETTLE - 1);
          st  <= EX_WAIT;
        end
        EX_WAIT: if (cnt_zero) st <= FIN; else cnt <= cnt - 1'b1;
        FIN: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign busy     = (st != IDLE);
  assign done     = (st == FIN);
  assign exp_req  = (st == PG_FETCH) || (st == VF_FETCH);
  assign exp_addr = addr;
  assign pulse_on = (st == ER_WAIT) || (st == PG_WAIT) || (st == VF_WAIT);
  assign sh_ir    = (st == EN_IR) || (st == ID_IR) || (st == ER_IR) ||
                    (st == PG_IR) || (st == VF_IR) || (st == EX_IR);
  assign sh_req   = sh_ir || (st == ID_DR) || (st == PG_DR) ||
                    (st == VF_ADR) || (st == VF_DR);

  always_comb begin
    sh_wdata = '0;
    case (st)
      EN_IR:  sh_wdata = SW'(OP_ENTER);
      ID_IR:  sh_wdata = SW'(OP_IDCODE);
      ER_IR:  sh_wdata = SW'(OP_ERASE);
      PG_IR:  sh_wdata = SW'(OP_PROG);
      VF_IR:  sh_wdata = SW'(OP_READ);
      EX_IR:  sh_wdata = SW'(OP_EXIT);
      PG_DR:  sh_wdata = {addr, dat};
      VF_ADR: sh_wdata = {addr, {DW{1'b0}}};
      default: sh_wdata = '0;
    endcase
  end

  always_comb begin
    case (st)
      EN_IR, EN_WAIT:                         stage = 3'd1;
      ID_IR, ID_DR:                           stage = 3'd2;
      ER_IR, ER_WAIT:                         stage = 3'd3;
      PG_FETCH, PG_IR, PG_DR, PG_WAIT:        stage = 3'd4;
      VF_FETCH, VF_IR, VF_ADR, VF_WAIT, VF_DR: stage = 3'd5;
      EX_IR, EX_WAIT:                         stage = 3'd6;
      default:                                stage = 3'd0;
    endcase
  end
endmodule

// File: rtl/isp_seq_chk.sv
module isp_seq_chk #(
  parameter int AW = 8,
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [2:0]    fail_stage,
  input logic [2:0]    stage,
  input logic          sh_req,
  input logic          sh_ir,
  input logic [SW-1:0] sh_wdata,
  input logic          sh_done,
  input logic          pulse_on,
  input logic          exp_req,
  input logic [AW-1:0] exp_addr,
  input logic          exp_valid
);
  // R11
  sh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_req && !sh_done |=> sh_req && $stable(sh_ir) && $stable(sh_wdata));

  // R11
  exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_req && !exp_valid |=> exp_req && $stable(exp_addr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> !sh_req && !exp_req);

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fail |=> fail);

  // R7
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (fail_stage == 3'd2 || fail_stage == 3'd5));

  // R1
  stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && stage != 3'd0 |=> stage == 3'd0 || stage >= $past(stage));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sh_req && !exp_req && !pulse_on && stage == 3'd0);
endmodule

bind isp_seq isp_seq_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
  .fail_stage(fail_stage), .stage(stage), .sh_req(sh_req), .sh_ir(sh_ir),
  .sh_wdata(sh_wdata), .sh_done(sh_done), .pulse_on(pulse_on),
  .exp_req(exp_req), .exp_addr(exp_addr), .exp_valid(exp_valid)
);

// File: tb/isp_seq_tb.sv
module isp_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 20000;
  localparam int NADDR = 8;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int IDW = 8;
  localparam int IRW = 6;
  localparam int SW = AW + DW;
  localparam int PROG_CYC = 5;
  localparam int READ_CYC = 3;
  localparam int SETTLE = CLK_HZ / 1000;
  localparam int ERASE = CLK_HZ / 10;
  localparam logic [IDW-1:0] EXP_ID = 8'hA5;
  localparam logic [IRW-1:0] O_EN = 6'h11, O_ID = 6'h12, O_ER = 6'h13,
                             O_PG = 6'h14, O_RD = 6'h15, O_EX = 6'h16;

  // {poke, verify_only, bad_id, corrupt, caddr[2:0], elat[1:0]}
  localparam int NV = 8;
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'b1_0_0_0_000_00,
    9'b0_1_0_0_000_10,
    9'b0_1_0_1_010_01,
    9'b0_0_0_1_000_11,
    9'b0_0_1_0_000_01,
    9'b0_1_1_0_000_00,
    9'b0_1_0_1_000_10,
    9'b1_1_0_1_111_00
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, verify_only = 1'b0;
  logic busy, done, fail, sh_req, sh_ir, pulse_on, exp_req;
  logic [2:0] fail_stage, stage;
  logic [AW-1:0] fail_addr, exp_addr;
  logic [SW-1:0] sh_wdata;
  logic sh_done = 1'b0, exp_valid = 1'b0;
  logic [SW-1:0] sh_rdata = '0;
  logic [DW-1:0] exp_data = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  isp_seq #(
    .CLK_HZ(CLK_HZ), .NADDR(NADDR), .DW(DW), .IDW(IDW), .IRW(IRW),
    .PROG_CYC(PROG_CYC), .READ_CYC(READ_CYC), .EXP_ID(EXP_ID),
    .OP_ENTER(O_EN), .OP_IDCODE(O_ID), .OP_ERASE(O_ER),
    .OP_PROG(O_PG), .OP_READ(O_RD), .OP_EXIT(O_EX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .verify_only(verify_only),
    .busy(busy), .done(done), .fail(fail), .fail_stage(fail_stage),
    .fail_addr(fail_addr), .stage(stage), .sh_req(sh_req), .sh_ir(sh_ir),
    .sh_wdata(sh_wdata), .sh_done(sh_done), .sh_rdata(sh_rdata),
    .pulse_on(pulse_on), .exp_req(exp_req), .exp_addr(exp_addr),
    .exp_valid(exp_valid), .exp_data(exp_data)
  );

  int total = 0, bad = 0, cyc = 0;
  bit wd_hit = 1'b0;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 29 + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // target device model
  logic [DW-1:0]  mem [0:NADDR-1];
  logic [IRW-1:0] oplog [0:511];
  int opn = 0;
  logic [IDW-1:0] id_val = EXP_ID;
  int sh_lat = 1, exp_lat = 0;
  logic [IRW-1:0] cur_op = '0;
  bit rd_phase = 1'b0;
  logic [AW-1:0] raddr = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (sh_req && !sh_done) begin
        repeat (sh_lat) @(negedge clk);
        sh_rdata = '0;
        if (sh_ir) begin
          cur_op = sh_wdata[IRW-1:0];
          rd_phase = 1'b0;
          oplog[opn] = cur_op;
          opn++;
          if (cur_op == O_ER)
            for (int i = 0; i < NADDR; i++) mem[i] = '1;
        end else if (cur_op == O_ID) begin
          sh_rdata = SW'(id_val);
        end else if (cur_op == O_PG) begin
          mem[sh_wdata[SW-1:DW]] = sh_wdata[DW-1:0];
        end else if (cur_op == O_RD) begin
          if (!rd_phase) begin
            raddr = sh_wdata[SW-1:DW];
            rd_phase = 1'b1;
          end else begin
            sh_rdata = SW'(mem[raddr]);
            rd_phase = 1'b0;
          end
        end
        sh_done = 1'b1;
        @(negedge clk);
        sh_done = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (exp_req && !exp_valid) begin
        repeat (exp_lat) @(negedge clk);
        exp_data = pat(int'(exp_addr));
        exp_valid = 1'b1;
        @(negedge clk);
        exp_valid = 1'b0;
      end
    end
  end

  int n_s1 = 0, n_s6 = 0, n_er = 0, n_pg = 0, n_rd = 0, n_done = 0;
  always @(negedge clk) begin
    if (stage == 3'd1 && !sh_req && !pulse_on) n_s1++;
    if (stage == 3'd6 && !sh_req && !pulse_on) n_s6++;
    if (pulse_on && stage == 3'd3) n_er++;
    if (pulse_on && stage == 3'd4) n_pg++;
    if (pulse_on && stage == 3'd5) n_rd++;
    if (done) n_done++;
  end

  task automatic run_one(input logic [8:0] v);
    logic poke, vo, bid, cor;
    int ca, b_s1, b_s6, b_er, b_pg, b_rd, b_dn, b_op, en, mis, k;
    logic [IRW-1:0] ex [0:63];
    bit exp_fail;
    poke = v[8]; vo = v[7]; bid = v[6]; cor = v[5]; ca = int'(v[4:2]);
    exp_lat = int'(v[1:0]);
    sh_lat = 1 + int'(v[0]);
    id_val = bid ? (EXP_ID ^ 8'h01) : EXP_ID;
    if (cor) begin
      for (int i = 0; i < NADDR; i++) mem[i] = pat(i);
      mem[ca] = ~pat(ca);
      mem[NADDR-1] = ~pat(NADDR - 1);
    end
    b_s1 = n_s1; b_s6 = n_s6; b_er = n_er; b_pg = n_pg; b_rd = n_rd;
    b_dn = n_done; b_op = opn;
    @(negedge clk);
    start = 1'b1; verify_only = vo;
    @(negedge clk);
    start = 1'b0; verify_only = 1'b0;
    chk(fail == 1'b0 && busy == 1'b1, "R10 start clears fail", int'(fail), 0);
    k = 0;
    while (!done && !wd_hit) begin
      @(negedge clk);
      k++;
      if (poke && k == 60) begin start = 1'b1; verify_only = ~vo; end
      else begin start = 1'b0; verify_only = 1'b0; end
    end
    start = 1'b0;
    exp_fail = bid || (vo && cor);
    chk(fail == exp_fail, "R7/R8 fail flag", int'(fail), int'(exp_fail));
    if (exp_fail)
      chk(fail_stage == (bid ? 3'd2 : 3'd5), "R7/R8 fail_stage",
          int'(fail_stage), bid ? 2 : 5);
    if (exp_fail && !bid)
      chk(int'(fail_addr) == ca, "R8 first failing address", int'(fail_addr), ca);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 done single cycle then idle",
        int'(done) + int'(busy), 0);
    chk(n_done - b_dn == 1, "R9 done width", n_done - b_dn, 1);
    en = 0;
    ex[en++] = O_EN; ex[en++] = O_ID;
    if (!bid) begin
      if (!vo) begin
        ex[en++] = O_ER;
        for (int i = 0; i < NADDR; i++) ex[en++] = O_PG;
      end
      for (int i = 0; i < NADDR; i++) ex[en++] = O_RD;
    end
    ex[en++] = O_EX;
    chk(opn - b_op == en, "R1/R2/R7 instruction count", opn - b_op, en);
    mis = 0;
    for (int i = 0; i < en; i++) if (oplog[b_op + i] != ex[i]) mis++;
    chk(mis == 0, vo ? "R2 instruction order" : "R1 instruction order", mis, 0);
    chk(n_s1 - b_s1 == SETTLE, "R3 enter settle", n_s1 - b_s1, SETTLE);
    chk(n_s6 - b_s6 == SETTLE, "R3 exit settle", n_s6 - b_s6, SETTLE);
    chk(n_er - b_er == ((vo || bid) ? 0 : ERASE), "R4 erase pulse",
        n_er - b_er, (vo || bid) ? 0 : ERASE);
    chk(n_pg - b_pg == ((vo || bid) ? 0 : NADDR * PROG_CYC), "R5 program pulses",
        n_pg - b_pg, (vo || bid) ? 0 : NADDR * PROG_CYC);
    chk(n_rd - b_rd == (bid ? 0 : NADDR * READ_CYC), "R6 read pulses",
        n_rd - b_rd, bid ? 0 : NADDR * READ_CYC);
    if (!vo && !bid) begin
      mis = 0;
      for (int i = 0; i < NADDR; i++) if (mem[i] != pat(i)) mis++;
      chk(mis == 0, "R5 programmed contents", mis, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < NADDR; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !sh_req && !exp_req && !pulse_on && stage == 3'd0,
        "R12 reset state", int'(busy) + int'(sh_req) + int'(stage), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NADDR; i++) mem[i] = '0;
    for (int n = 0; n < NV; n++) begin
      run_one(VEC[n]);
      repeat (5) @(negedge clk);
      chk(!busy && !sh_req, "R10 no restart after ignored start",
          int'(busy) + int'(sh_req), 0);
    end
    // mid-run reset
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !sh_req && !exp_req && !pulse_on && stage == 3'd0 && !done,
        "R12 reset during run", int'(busy) + int'(stage), 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && stage == 3'd0, "R12 idle after reset", int'(stage), 0);
    run_one(9'b0_0_0_0_000_01);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule